// File: doc/BRIEF.md
# Flash Read-Error Refresh and Retirement Monitor

The ECC engine reports, after every flash read, how many bits it had to correct. This monitor grades each report against two programmable limits. A moderate count asks the data mover to rewrite the block where it is (a refresh). A heavier count asks it to copy the data to a healthy block and to stop using the old one (a retirement). Moving the data is not part of this block.

Requests are held on the outputs until the data mover acknowledges them. A single spare register holds one more request while the first is outstanding. Any event that arrives when both places are full is dropped and raises a sticky overflow flag. A bitmap with one bit per block records every block that has been retired. A separate query port reads this bitmap, and reads of a marked block produce no further requests. If the limits are programmed so that the retirement limit is not above the refresh limit, the configuration is reported as invalid and no request is raised.

Top module: `hm_rd_health`

## Requirements
- R1: A read (`rd_done` high) on an unmarked block with `thr_retire` > `thr_refresh` and `thr_refresh` <= `rd_errs` <= `thr_retire` raises a refresh request: `refresh_req` high with `req_blk` equal to the block. When no request is pending, this appears in the cycle after the read.
- R2: A read whose `rd_errs` is strictly above `thr_retire` raises a retirement request (`retire_req`) instead of a refresh. Retirement wins whenever both limits are crossed.
- R3: A read with `rd_errs` below `thr_refresh` raises no request.
- R4: When a retirement request is accepted, its block is marked bad. `chk_bad` for that block reads 1 from the cycle after the read, and a marked bit never clears until reset.
- R5: A read on a block that is already marked bad raises no request and leaves the flags unchanged.
- R6: `cfg_bad` is high whenever `thr_retire` <= `thr_refresh`. While it is high, reads raise no request and mark no block.
- R7: A presented request, with its kind and block, stays unchanged until `req_ack` is sampled high. It is removed at that clock edge. `busy` is high exactly while a request is presented.
- R8: An event that arrives while a request is presented and the spare register is empty is kept. It is presented after the acknowledge edge, in arrival order.
- R9: An event that arrives while both the presented slot and the spare register are full is dropped and sets `ovf`. `ovf` stays set until reset, and a dropped retirement does not mark its block.
- R10: After reset, `refresh_req`, `retire_req`, `busy` and `ovf` are low, and every block reads as unmarked.
- R11: `refresh_req` and `retire_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_done | input | 1 | One-cycle strobe: a read finished and its error count is valid |
| rd_blk | input | BLK_W | Block index of that read |
| rd_errs | input | CNT_W | Number of bits the ECC engine corrected |
| thr_refresh | input | CNT_W | Lowest count that requests a refresh |
| thr_retire | input | CNT_W | Counts strictly above this value request a retirement |
| req_ack | input | 1 | Data mover accepts the presented request |
| refresh_req | output | 1 | A refresh request is presented |
| retire_req | output | 1 | A retirement request is presented |
| req_blk | output | BLK_W | Block of the presented request |
| busy | output | 1 | A request is waiting for acknowledge |
| ovf | output | 1 | Sticky flag: an event was dropped |
| cfg_bad | output | 1 | The limits are inconsistent |
| chk_blk | input | BLK_W | Block to look up in the bad-block bitmap |
| chk_bad | output | 1 | The looked-up block is marked bad |

## Verification
Error counts are applied just below, exactly at and just above each limit. This separates `>=` from `>` on the refresh side and on the retirement side. A count equal to the retirement limit must still give a refresh. Reads are repeated on a block that has just been retired, which shows whether the bitmap gates new requests from the very next cycle. Events are issued back-to-back while no acknowledge is given, which tells the spare register apart from the overflow path and shows whether a dropped retirement leaves its bit clear. Equal limits and swapped limits check that the invalid configuration blocks both kinds of request.

// File: rtl/hm_pkg.sv
package hm_pkg;

  typedef enum logic [1:0] {
    K_NONE    = 2'd0,
    K_REFRESH = 2'd1,
    K_RETIRE  = 2'd2
  } kind_e;

  // The limits are usable only when the relocation limit lies strictly above
  // the rewrite limit.
  function automatic logic f_cfg_ok(input int unsigned thr_ref,
                                    input int unsigned thr_ret);
    return thr_ret > thr_ref;
  endfunction

  // Grade one read. The relocation test is made first, so it takes priority.
  function automatic kind_e f_grade(input int unsigned errs,
                                    input int unsigned thr_ref,
                                    input int unsigned thr_ret,
                                    input logic        blk_bad);
    if (!f_cfg_ok(thr_ref, thr_ret)) return K_NONE;
    if (blk_bad)                     return K_NONE;
    if (errs > thr_ret)              return K_RETIRE;
    if (errs >= thr_ref)             return K_REFRESH;
    return K_NONE;
  endfunction

endpackage

// File: rtl/hm_classify.sv
module hm_classify
  import hm_pkg::*;
#(
  parameter int CNT_W = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_done,
  input  logic [CNT_W-1:0] rd_errs,
  input  logic [CNT_W-1:0] thr_ref,
  input  logic [CNT_W-1:0] thr_ret,
  input  logic             blk_bad,
  output logic             ev_vld,
  output kind_e            ev_kind,
  output logic             cfg_bad
);

  kind_e grade;

  always_comb begin
    grade   = f_grade(32'(rd_errs), 32'(thr_ref), 32'(thr_ret), blk_bad);
    cfg_bad = !f_cfg_ok(32'(thr_ref), 32'(thr_ret));
    ev_vld  = rd_done && (grade != K_NONE);
    ev_kind = grade;
  end

  AST_CFG_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_ret <= thr_ref) |-> !ev_vld);  // R6
  AST_BAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && blk_bad) |-> !ev_vld);  // R5
  AST_RETIRE_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vld && ev_kind == K_RETIRE) |-> (rd_errs > thr_ret));  // R2
  AST_REFRESH_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vld && ev_kind == K_REFRESH) |-> (rd_errs >= thr_ref && rd_errs <= thr_ret));  // R1

endmodule

// File: rtl/hm_badmap.sv
module hm_badmap #(
  parameter int NBLK  = 64,
  parameter int BLK_W = $clog2(NBLK)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [BLK_W-1:0] set_blk,
  input  logic [BLK_W-1:0] look_blk,
  output logic             look_bad,
  input  logic [BLK_W-1:0] chk_blk,
  output logic             chk_bad
);

  logic [NBLK-1:0] bits_q;

  for (genvar i = 0; i < NBLK; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                                  bits_q[i] <= 1'b0;
      else if (set_en && set_blk == BLK_W'(i))     bits_q[i] <= 1'b1;
    end
  end

  assign look_bad = bits_q[look_blk];
  assign chk_bad  = bits_q[chk_blk];

  AST_BAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((bits_q & $past(bits_q)) == $past(bits_q)));  // R4
  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> bits_q[$past(set_blk)]);  // R4

endmodule

// File: rtl/hm_reqslots.sv
module hm_reqslots
  import hm_pkg::*;
#(
  parameter int BLK_W = 6
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_vld,
  input  kind_e            ev_kind,
  input  logic [BLK_W-1:0] ev_blk,
  input  logic             ack,
  output logic             accept,
  output logic             out_vld,
  output kind_e            out_kind,
  output logic [BLK_W-1:0] out_blk,
  output logic             q_vld,
  output logic             ovf
);

  kind_e            q_kind;
  logic [BLK_W-1:0] q_blk;
  logic             take;     // presented slot retires this edge
  logic             full;     // no room for a new event

  assign take   = out_vld && ack;
  assign full   = out_vld && !take && q_vld;
  assign accept = ev_vld && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_kind <= K_NONE;
      out_blk  <= '0;
      q_vld    <= 1'b0;
      q_kind   <= K_NONE;
      q_blk    <= '0;
      ovf      <= 1'b0;
    end else if (out_vld && !take) begin
      if (ev_vld && !q_vld) begin
        q_vld  <= 1'b1;
        q_kind <= ev_kind;
        q_blk  <= ev_blk;
      end else if (ev_vld) begin
        ovf <= 1'b1;
      end
    end else if (q_vld) begin
      out_vld  <= 1'b1;
      out_kind <= q_kind;
      out_blk  <= q_blk;
      q_vld    <= ev_vld;
      q_kind   <= ev_kind;
      q_blk    <= ev_blk;
    end else begin
      out_vld  <= ev_vld;
      out_kind <= ev_kind;
      out_blk  <= ev_blk;
    end
  end

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !ack) |=> (out_vld && $stable(out_kind) && $stable(out_blk)));  // R7
  AST_QUEUE_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld |-> out_vld);  // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);  // R9
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vld && !accept) |=> ovf);  // R9

endmodule

// File: rtl/hm_rd_health.sv
module hm_rd_health
  import hm_pkg::*;
#(
  parameter int NBLK  = 64,
  parameter int CNT_W = 8,
  parameter int BLK_W = $clog2(NBLK)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_done,
  input  logic [BLK_W-1:0] rd_blk,
  input  logic [CNT_W-1:0] rd_errs,
  input  logic [CNT_W-1:0] thr_refresh,
  input  logic [CNT_W-1:0] thr_retire,
  input  logic             req_ack,
  output logic             refresh_req,
  output logic             retire_req,
  output logic [BLK_W-1:0] req_blk,
  output logic             busy,
  output logic             ovf,
  output logic             cfg_bad,
  input  logic [BLK_W-1:0] chk_blk,
  output logic             chk_bad
);

  logic  blk_bad;
  logic  ev_vld;
  kind_e ev_kind;
  logic  accept;
  logic  mark_en;
  logic  out_vld;
  kind_e out_kind;
  logic  q_vld;

  hm_classify #(.CNT_W(CNT_W)) u_cls (
    .clk(clk), .rst_n(rst_n), .rd_done(rd_done), .rd_errs(rd_errs),
    .thr_ref(thr_refresh), .thr_ret(thr_retire), .blk_bad(blk_bad),
    .ev_vld(ev_vld), .ev_kind(ev_kind), .cfg_bad(cfg_bad)
  );

  assign mark_en = accept && (ev_kind == K_RETIRE);

  hm_badmap #(.NBLK(NBLK), .BLK_W(BLK_W)) u_map (
    .clk(clk), .rst_n(rst_n), .set_en(mark_en), .set_blk(rd_blk),
    .look_blk(rd_blk), .look_bad(blk_bad), .chk_blk(chk_blk), .chk_bad(chk_bad)
  );

  hm_reqslots #(.BLK_W(BLK_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .ev_vld(ev_vld), .ev_kind(ev_kind), .ev_blk(rd_blk),
    .ack(req_ack), .accept(accept), .out_vld(out_vld), .out_kind(out_kind),
    .out_blk(req_blk), .q_vld(q_vld), .ovf(ovf)
  );

  assign refresh_req = out_vld && (out_kind == K_REFRESH);
  assign retire_req  = out_vld && (out_kind == K_RETIRE);
  assign busy        = out_vld;

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({refresh_req, retire_req}));  // R11
  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (refresh_req || retire_req));  // R7
  AST_NO_MARK_WHEN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |-> !mark_en);  // R6

endmodule

// File: tb/tb_hm_rd_health.sv
module tb_hm_rd_health;
  localparam int NBLK  = 64;
  localparam int CNT_W = 8;
  localparam int BLK_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_done = 1'b0;
  logic [BLK_W-1:0] rd_blk = '0;
  logic [CNT_W-1:0] rd_errs = '0;
  logic [CNT_W-1:0] thr_refresh = 8'd10;
  logic [CNT_W-1:0] thr_retire = 8'd20;
  logic req_ack = 1'b0;
  logic [BLK_W-1:0] chk_blk = '0;
  logic refresh_req, retire_req, busy, ovf, cfg_bad, chk_bad;
  logic [BLK_W-1:0] req_blk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int pend[$];          // entries: kind*1024 + block; kind 1 refresh, 2 retire
  bit mbad[NBLK];
  bit movf = 0;

  always #4 clk = ~clk;

  hm_rd_health #(.NBLK(NBLK), .CNT_W(CNT_W), .BLK_W(BLK_W)) dut (
    .clk(clk), .rst_n(rst_n), .rd_done(rd_done), .rd_blk(rd_blk), .rd_errs(rd_errs),
    .thr_refresh(thr_refresh), .thr_retire(thr_retire), .req_ack(req_ack),
    .refresh_req(refresh_req), .retire_req(retire_req), .req_blk(req_blk),
    .busy(busy), .ovf(ovf), .cfg_bad(cfg_bad), .chk_blk(chk_blk), .chk_bad(chk_bad)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model update on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      pend.delete();
      for (int i = 0; i < NBLK; i++) mbad[i] = 0;
      movf = 0;
    end else begin
      int k;
      if (req_ack && pend.size() > 0) void'(pend.pop_front());
      k = 0;
      if (rd_done && int'(thr_retire) > int'(thr_refresh) && !mbad[rd_blk]) begin
        if (int'(rd_errs) > int'(thr_retire))       k = 2;
        else if (int'(rd_errs) >= int'(thr_refresh)) k = 1;
      end
      if (k != 0) begin
        if (pend.size() < 2) begin
          pend.push_back(k * 1024 + int'(rd_blk));
          if (k == 2) mbad[rd_blk] = 1;
        end else begin
          movf = 1;
        end
      end
    end
  end

  // compare against the model every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      int ek;
      ek = (pend.size() > 0) ? pend[0] / 1024 : 0;
      check(refresh_req == (ek == 1), "R1 refresh_req vs model", refresh_req, ek == 1);
      check(retire_req == (ek == 2), "R2 retire_req vs model", retire_req, ek == 2);
      if (ek != 0)
        check(int'(req_blk) == pend[0] % 1024, "R7 req_blk vs model", req_blk, pend[0] % 1024);
      check(busy == (ek != 0), "R7 busy vs model", busy, ek != 0);
      check(ovf == movf, "R9 ovf vs model", ovf, movf);
      check(cfg_bad == (thr_retire <= thr_refresh), "R6 cfg_bad vs model", cfg_bad,
            thr_retire <= thr_refresh);
      check(chk_bad == mbad[chk_blk], "R4 chk_bad vs model", chk_bad, mbad[chk_blk]);
      check(!(refresh_req && retire_req), "R11 exclusive", refresh_req + retire_req, 1);
    end
  end

  task automatic rd(input int blk, input int errs);
    @(negedge clk); #1;
    rd_blk = BLK_W'(blk); rd_errs = CNT_W'(errs); rd_done = 1'b1;
    @(negedge clk); #1;
    rd_done = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); #1;
    req_ack = 1'b1;
    @(negedge clk); #1;
    req_ack = 1'b0;
  endtask

  task automatic peek(input int blk, output bit b);
    chk_blk = BLK_W'(blk);
    #1;
    b = chk_bad;
  endtask

  initial begin : watchdog
    while (!done && cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    bit b;
    repeat (3) @(negedge clk);
    #1;
    // R10: reset state
    check(!refresh_req && !retire_req && !busy && !ovf, "R10 outputs after reset",
          {refresh_req, retire_req, busy, ovf}, 0);
    for (int i = 0; i < NBLK; i += 21) begin
      peek(i, b);
      check(b == 0, "R10 bitmap clear", b, 0);
    end
    @(negedge clk); #1;
    rst_n = 1'b1;

    // R3: below the refresh limit
    rd(3, 9);
    check(!busy, "R3 below limit silent", busy, 0);
    // R1: at the refresh limit
    rd(3, 10);
    check(refresh_req && req_blk == 3, "R1 refresh at limit", {refresh_req, req_blk}, 64 + 3);
    ack();
    check(!busy, "R7 cleared after ack", busy, 0);
    // R1: equal to the relocation limit is still a refresh
    rd(4, 20);
    check(refresh_req && !retire_req, "R1 refresh at retire limit", refresh_req, 1);
    ack();
    // R2: above relocation limit, and R4 marking
    rd(7, 21);
    check(retire_req && req_blk == 7, "R2 retire above limit", {retire_req, req_blk}, 64 + 7);
    peek(7, b);
    check(b == 1, "R4 block marked", b, 1);
    ack();
    // R5: marked block is silent
    rd(7, 200);
    check(!busy, "R5 bad block silent", busy, 0);

    // R7/R8/R9: queue and overflow
    rd(8, 12);
    rd(9, 15);
    check(refresh_req && req_blk == 8, "R7 first held", req_blk, 8);
    rd(10, 30);
    check(ovf == 1, "R9 overflow set", ovf, 1);
    peek(10, b);
    check(b == 0, "R9 dropped retire not marked", b, 0);
    repeat (3) @(negedge clk);
    check(req_blk == 8, "R7 held without ack", req_blk, 8);
    ack();
    check(refresh_req && req_blk == 9, "R8 queued follows", req_blk, 9);
    ack();
    check(!busy && ovf, "R9 ovf sticky", {busy, ovf}, 1);
    // R8: event arriving on the acknowledge edge
    rd(11, 25);
    rd(12, 11);
    @(negedge clk); #1;
    req_ack = 1'b1; rd_blk = 6'd13; rd_errs = 8'd40; rd_done = 1'b1;
    @(negedge clk); #1;
    req_ack = 1'b0; rd_done = 1'b0;
    check(refresh_req && req_blk == 12, "R8 order after ack", req_blk, 12);
    ack();
    check(retire_req && req_blk == 13, "R8 arrival order kept", req_blk, 13);
    ack();

    // R6: equal and swapped limits
    thr_refresh = 8'd20; thr_retire = 8'd20;
    rd(20, 50);
    check(cfg_bad && !busy, "R6 equal limits block", {cfg_bad, busy}, 2);
    peek(20, b);
    check(b == 0, "R6 no marking", b, 0);
    thr_refresh = 8'd30; thr_retire = 8'd5;
    rd(21, 25);
    check(cfg_bad && !busy, "R6 swapped limits block", {cfg_bad, busy}, 2);
    thr_refresh = 8'd1; thr_retire = 8'd2;
    rd(22, 3);
    check(!cfg_bad && retire_req && req_blk == 22, "R2 retire after valid cfg", req_blk, 22);
    ack();
    rd(63, 1);
    check(refresh_req && req_blk == 63, "R1 top block index", req_blk, 63);
    ack();

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule